// File: doc/BRIEF.md
# Multi-Threshold Pulse-Height Counter Bank

This block sorts detector pulses into coarse amplitude bins. Every channel of a multichannel readout chip delivers five comparator outputs. All channels share the same five thresholds, which are set outside the block. The block keeps one counter for each comparator. A pulse that rises above a threshold adds one count to that level, so the five counters of a channel together form a five-bin pulse-height histogram. Comparator outputs are asynchronous. Each one is synchronized and then edge-detected, so a pulse of any width adds exactly one count.

Readout runs through one shared serial path. A request freezes a snapshot of every counter and restarts the live counters from zero in the same clock cycle, so no pulse is lost across the boundary. The snapshot is then streamed out one word per cycle. Each word carries its channel and level tags, and a marker flags the final word. A separate clear strobe zeroes the live counters without producing any readout.

Top module: `pha_counter_bank`

## Requirements
- R1: After reset, `rd_valid` and `rd_last` are low and every counter holds zero. A readout taken before any pulse returns all zeros.
- R2: A rising edge on a comparator input adds exactly one to that input's counter. An input that is held high for many cycles still counts once.
- R3: Input bit `ch*5+k` of `cmp_in` is level k+1 of channel ch, and each of the 160 counters responds only to its own bit. A pulse that crosses the lowest m levels adds one to each of those m counters and to no other counter.
- R4: Counters are 16 bits wide. They hold at 65535 instead of wrapping around.
- R5: A new pulse every two clock cycles on any input is counted without loss.
- R6: When `rd_req` is sampled high while no readout is running, all counters are copied to the snapshot and the live counters restart in that same cycle. An edge that lands in that same cycle is left out of this snapshot and leaves its counter at 1, so it appears in the next readout.
- R7: The readout begins on the clock after the request. It emits 160 words on consecutive cycles. The order is channel 0 to 31, and within each channel `rd_lvl` goes from 0 to 4, encoding levels 1 to 5. `rd_last` is high on the final word only.
- R8: `rd_req` has no effect while a readout is in progress. No extra words are emitted, and the live counters are not cleared.
- R9: `clr_i` zeroes all live counters. An edge that lands in the same cycle leaves its counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 160 | Asynchronous comparator outputs, bit ch*5+k = channel ch, level k+1 |
| clr_i | input | 1 | Synchronous strobe that zeroes the live counters |
| rd_req | input | 1 | Readout request: takes a snapshot and starts the stream |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | 16 | Snapshot count |
| rd_chan | output | 5 | Channel tag of the word |
| rd_lvl | output | 3 | Level tag, 0 to 4 for levels 1 to 5 |
| rd_last | output | 1 | High on the final word of a readout |

## Verification
The hardest case to reach is an edge that lands on the same clock as a snapshot or a clear. A comparator change needs two synchronizer stages and the edge detector before it reaches a counter. The stimulus therefore raises one comparator bit and asserts `rd_req` (or `clr_i`) exactly two falling edges later, so both arrive at the counters on one edge. The scoreboard then expects that count in the following readout rather than the current one. Saturation is reached by toggling every input every cycle for more than 65535 pulses, which also exercises the maximum count rate.

// File: rtl/pha_pkg.sv
// Package: shared defaults and the readout sequencer state type.
package pha_pkg;
    localparam int NCH_DEF  = 32;
    localparam int NLVL_DEF = 5;
    localparam int CW_DEF   = 16;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_BUSY = 1'b1
    } rd_state_e;
endpackage

// File: rtl/pha_edge_sync.sv
// Module: pha_edge_sync
// Brings W asynchronous comparator bits into the clock domain through two
// flops each and produces a one-cycle pulse on every rising edge.
// Assumes each input stays at a level for at least one clock period.
module pha_edge_sync #(
    parameter int W = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A rising edge is a high synchronized level whose previous value was low.
    always_comb rise = sync_q & ~prev_q;
endmodule

// File: rtl/pha_level_counter.sv
// Module: pha_level_counter
// One saturating counter for a single channel and level, with a snapshot
// register. A snapshot or a clear restarts the count at zero, or at one
// when a hit arrives in the same cycle, so no hit is lost.
// Assumes hit is a single-cycle pulse from the edge detector.
module pha_level_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          clr,
    input  logic          snap,
    output logic [CW-1:0] snap_val
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] count_q;

    // Live count: restart on snapshot or clear, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr || snap) begin
            count_q <= hit ? CW'(1) : '0;
        end else if (hit && count_q != CMAX) begin
            count_q <= count_q + CW'(1);
        end
    end

    // Snapshot register, loaded with the pre-restart count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_val <= '0;
        end else if (snap) begin
            snap_val <= count_q;
        end
    end
endmodule

// File: rtl/pha_readout_seq.sv
// Module: pha_readout_seq
// Accepts a readout request when idle, orders the snapshot, and streams the
// snapshot words channel-major, level-minor, one per cycle, with tags and a
// last marker. Requests that arrive while streaming are ignored.
// Assumes rd_req is synchronous to clk.
module pha_readout_seq
    import pha_pkg::*;
#(
    parameter int NCH  = 32,
    parameter int NLVL = 5,
    parameter int CW   = 16,
    parameter int CHW  = $clog2(NCH),
    parameter int LVW  = $clog2(NLVL)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req,
    input  logic [NCH*NLVL*CW-1:0] snap_bus,
    output logic                   snap_go,
    output logic                   rd_valid,
    output logic [CW-1:0]          rd_data,
    output logic [CHW-1:0]         rd_chan,
    output logic [LVW-1:0]         rd_lvl,
    output logic                   rd_last
);
    localparam int NTOT = NCH * NLVL;
    localparam int IW   = $clog2(NTOT);

    rd_state_e      state_q;
    logic [CHW-1:0] ch_q;
    logic [LVW-1:0] lv_q;
    logic [IW-1:0]  idx;
    logic [CW-1:0]  word;
    logic           at_end;
    logic           lvl_wrap;

    // A snapshot is taken only for a request seen while idle.
    always_comb snap_go = (state_q == RD_IDLE) && rd_req;

    // Flat index of the current word and its snapshot value.
    always_comb begin
        idx      = IW'(ch_q) * IW'(NLVL) + IW'(lv_q);
        word     = snap_bus[idx*CW +: CW];
        lvl_wrap = (lv_q == LVW'(NLVL - 1));
        at_end   = lvl_wrap && (ch_q == CHW'(NCH - 1));
    end

    // Sequencer state, position counters and registered output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RD_IDLE;
            ch_q     <= '0;
            lv_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_chan  <= '0;
            rd_lvl   <= '0;
            rd_last  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (rd_req) begin
                        state_q <= RD_BUSY;
                        ch_q    <= '0;
                        lv_q    <= '0;
                    end
                end
                RD_BUSY: begin
                    rd_valid <= 1'b1;
                    rd_data  <= word;
                    rd_chan  <= ch_q;
                    rd_lvl   <= lv_q;
                    rd_last  <= at_end;
                    if (at_end) begin
                        state_q <= RD_IDLE;
                    end else if (lvl_wrap) begin
                        lv_q <= '0;
                        ch_q <= ch_q + CHW'(1);
                    end else begin
                        lv_q <= lv_q + LVW'(1);
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pha_counter_bank.sv
// Module: pha_counter_bank (top)
// Coarse pulse-height analysis: NCH channels with NLVL shared-threshold
// comparators each. Every comparator edge counts into its own saturating
// counter, and a request streams a snapshot of all counters out.
// Assumes clr_i and rd_req are synchronous and cmp_in is asynchronous.
module pha_counter_bank
    import pha_pkg::*;
#(
    parameter int NCH  = NCH_DEF,
    parameter int NLVL = NLVL_DEF,
    parameter int CW   = CW_DEF,
    parameter int CHW  = $clog2(NCH),
    parameter int LVW  = $clog2(NLVL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*NLVL-1:0]  cmp_in,
    input  logic                 clr_i,
    input  logic                 rd_req,
    output logic                 rd_valid,
    output logic [CW-1:0]        rd_data,
    output logic [CHW-1:0]       rd_chan,
    output logic [LVW-1:0]       rd_lvl,
    output logic                 rd_last
);
    localparam int NTOT = NCH * NLVL;

    logic [NTOT-1:0]    hit;
    logic [NTOT*CW-1:0] snap_bus;
    logic               snap_go;

    pha_edge_sync #(.W(NTOT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_in),
        .rise  (hit)
    );

    // One counter per channel and level, flattened as ch*NLVL+level.
    for (genvar i = 0; i < NTOT; i++) begin : g_cnt
        pha_level_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[i]),
            .clr      (clr_i),
            .snap     (snap_go),
            .snap_val (snap_bus[i*CW +: CW])
        );
    end

    pha_readout_seq #(
        .NCH  (NCH),
        .NLVL (NLVL),
        .CW   (CW),
        .CHW  (CHW),
        .LVW  (LVW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .snap_bus (snap_bus),
        .snap_go  (snap_go),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_chan  (rd_chan),
        .rd_lvl   (rd_lvl),
        .rd_last  (rd_last)
    );
endmodule

// File: rtl/pha_counter_bank_chk.sv
// Module: pha_counter_bank_chk
// Port-level protocol checks on the readout stream, bound to the top.
module pha_counter_bank_chk #(
    parameter int NCH  = 32,
    parameter int NLVL = 5,
    parameter int CW   = 16,
    parameter int CHW  = $clog2(NCH),
    parameter int LVW  = $clog2(NLVL)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_req,
    input logic           rd_valid,
    input logic [CW-1:0]  rd_data,
    input logic [CHW-1:0] rd_chan,
    input logic [LVW-1:0] rd_lvl,
    input logic           rd_last
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rd_valid && !rd_last);

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R7
    burst_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_last |=> rd_valid);

    // R7
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> !rd_valid);

    // R7
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (rd_chan == '0) && (rd_lvl == '0));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_last |=>
            ((rd_lvl == '0) ? (rd_chan == $past(rd_chan) + CHW'(1))
                            : (rd_chan == $past(rd_chan) && rd_lvl == $past(rd_lvl) + LVW'(1))));

    // R3
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (32'(rd_lvl) < NLVL));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_last && rd_req |=> !(rd_chan == '0 && rd_lvl == '0));
endmodule

bind pha_counter_bank pha_counter_bank_chk #(
    .NCH  (NCH),
    .NLVL (NLVL),
    .CW   (CW),
    .CHW  (CHW),
    .LVW  (LVW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_chan  (rd_chan),
    .rd_lvl   (rd_lvl),
    .rd_last  (rd_last)
);

// File: tb/sim_pha_counter_bank.sv
// Scoreboard bench: driver tasks keep a model of every counter and push the
// expected readout words into a queue; a monitor pops and compares them.
module sim_pha_counter_bank;
    localparam int NCH  = 32;
    localparam int NLVL = 5;
    localparam int NTOT = NCH * NLVL;
    localparam int CMAX = 65535;

    typedef struct {
        int    d;
        int    c;
        int    l;
        bit    last;
        string tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NTOT-1:0] cmp_in = '0;
    logic            clr_i = 1'b0;
    logic            rd_req = 1'b0;
    logic            rd_valid;
    logic [15:0]     rd_data;
    logic [4:0]      rd_chan;
    logic [2:0]      rd_lvl;
    logic            rd_last;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    int    expc [NTOT];
    item_t q [$];

    always #4 clk = ~clk;

    pha_counter_bank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_in   (cmp_in),
        .clr_i    (clr_i),
        .rd_req   (rd_req),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_chan  (rd_chan),
        .rd_lvl   (rd_lvl),
        .rd_last  (rd_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic add_hits(input logic [NTOT-1:0] v);
        for (int i = 0; i < NTOT; i++)
            if (v[i] && expc[i] < CMAX) expc[i]++;
    endtask

    // One pulse of two cycles high, two cycles low on the chosen bits.
    task automatic pulse(input logic [NTOT-1:0] v);
        @(negedge clk) cmp_in = v;
        idle(2);
        cmp_in = '0;
        idle(2);
        add_hits(v);
    endtask

    task automatic push_all(input string tag);
        for (int i = 0; i < NTOT; i++) begin
            item_t it;
            it.d = expc[i];
            it.c = i / NLVL;
            it.l = i % NLVL;
            it.last = (i == NTOT - 1);
            it.tag = tag;
            q.push_back(it);
            expc[i] = 0;
        end
    endtask

    // Settle the synchronizers, queue the expected stream, request it, drain.
    task automatic readout(input string tag);
        idle(4);
        push_all(tag);
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        idle(NTOT + 6);
    endtask

    // Raise one bit so its edge reaches the counters on the same clock as a
    // snapshot (use_clr=0) or a clear (use_clr=1).
    task automatic boundary(input int b, input bit use_clr, input string tag);
        idle(4);
        @(negedge clk) cmp_in[b] = 1'b1;
        idle(2);
        if (use_clr) begin
            clr_i = 1'b1;
            for (int i = 0; i < NTOT; i++) expc[i] = 0;
        end else begin
            push_all(tag);
            rd_req = 1'b1;
        end
        @(negedge clk);
        clr_i = 1'b0;
        rd_req = 1'b0;
        cmp_in = '0;
        expc[b] = 1;
        idle(NTOT + 6);
    endtask

    // Monitor: compare every readout word against the queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid && !done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 unexpected word", 1, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(int'(rd_data) == it.d, it.tag, int'(rd_data), it.d);
                chk(int'(rd_chan) == it.c && int'(rd_lvl) == it.l,
                    "R7 tag order", int'(rd_chan) * 8 + int'(rd_lvl), it.c * 8 + it.l);
                chk(rd_last == it.last, "R7 last marker", int'(rd_last), int'(it.last));
            end
        end
    end

    initial begin
        for (int i = 0; i < NTOT; i++) expc[i] = 0;
        idle(5);
        // R1: quiet outputs in reset and just after it.
        chk(rd_valid == 1'b0 && rd_last == 1'b0, "R1 reset outputs", int'(rd_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        chk(rd_valid == 1'b0, "R1 idle after reset", int'(rd_valid), 0);
        readout("R1");

        // R3: thermometer patterns, channel ch crosses its lowest ch%6 levels.
        for (int rep = 0; rep < 2; rep++)
            for (int ch = 0; ch < NCH; ch++) begin
                logic [NTOT-1:0] v;
                v = '0;
                for (int k = 0; k < (ch + rep) % 6; k++) v[ch*NLVL + k] = 1'b1;
                pulse(v);
            end
        readout("R3");

        // R2: a level held high for a long time counts once.
        @(negedge clk) cmp_in[12] = 1'b1;
        idle(60);
        cmp_in[12] = 1'b0;
        expc[12] = 1;
        pulse({{(NTOT-13){1'b0}}, 13'h1000});
        readout("R2");

        // R6: edge landing on the snapshot cycle goes to the next readout.
        pulse({{(NTOT-8){1'b0}}, 8'h41});
        boundary(77, 1'b0, "R6");
        readout("R6");

        // R9: clear with a coincident edge leaves exactly that one count.
        pulse({NTOT{1'b1}});
        pulse({NTOT{1'b1}});
        boundary(150, 1'b1, "R9");
        readout("R9");

        // R8: a second request and a pulse during streaming.
        idle(4);
        push_all("R8");
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        idle(30);
        pulse({{(NTOT-8){1'b0}}, 8'h80});
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        idle(NTOT);
        readout("R8");

        // R5: one pulse every two cycles on every input.
        for (int n = 0; n < 1000; n++) begin
            @(negedge clk) cmp_in = '1;
            @(negedge clk) cmp_in = '0;
        end
        add_hits('1);
        for (int i = 0; i < NTOT; i++) expc[i] = 1000;
        readout("R5");

        // R4: drive past the 16-bit limit and expect saturation.
        for (int n = 0; n < CMAX + 5; n++) begin
            @(negedge clk) cmp_in = '1;
            @(negedge clk) cmp_in = '0;
        end
        for (int i = 0; i < NTOT; i++) expc[i] = CMAX;
        readout("R4");

        chk(q.size() == 0, "R7 all words delivered", q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule